// File: doc/BRIEF.md
# Legacy UART register interface

This block presents a classic eight-register serial-port programming model on a byte-wide memory-mapped bus, with a byte-stream console on its far side instead of a serial line. Software reads received bytes, writes bytes to transmit, programs the interrupt enables and the line and modem controls, and polls line status. None of this needs a baud generator, a shift register or a FIFO. Received bytes come in as a valid/data pair and leave through a pop strobe. Transmitted bytes leave as a one-cycle valid pulse with data.

The interrupt logic follows simplified rules. A receive interrupt exists while a byte is waiting and receive interrupts are enabled. A transmit interrupt is a sticky pending flag. Enabling the transmit-empty interrupt or writing a byte while it is enabled sets the flag, and reading the identification register clears it. Line status always reports an idle transmitter. The modem status and scratch locations read as zero. The modem control register only answers a loopback probe pattern. The divisor latch is decoded but holds nothing.

Top module: `legacy_uart_regs`

## Requirements
- R1: After reset, bus_rdata, tx_valid and irq are 0, the line control, interrupt enable and modem control registers read 0, and no transmit interrupt is pending (identification reads 0x01).
- R2: A read presents its data on bus_rdata in the cycle after the read strobe, and bus_rdata is 0 in a cycle that follows no read.
- R3: With line control bit 7 clear, a read of offset 0 returns rx_data and pulses rx_pop in the strobe cycle when rx_valid is 1. When rx_valid is 0, it returns 0 with no pop.
- R4: With line control bit 7 set, offsets 0 and 1 read 0, and writes to them do not transmit and do not change the interrupt enable register. Reads of them do not pop.
- R5: The identification register (offset 2) reads 0x04 when rx_valid is 1 and enable bit 0 is set. Otherwise it reads 0x02 when a transmit interrupt is pending, and otherwise 0x01.
- R6: Every read of offset 2 clears the pending transmit interrupt, including a read that reports 0x04.
- R7: Line status (offset 5) reads 0x61 when rx_valid is 1 and 0x60 otherwise: bit 0 data ready, bit 5 holding register empty, bit 6 transmitter empty.
- R8: Offsets 6 and 7 always read 0. Writes to offsets 2, 5, 6 and 7 change no register and do not transmit.
- R9: A write to offset 0 with line control bit 7 clear gives a one-cycle tx_valid with tx_data equal to the byte in the next cycle. It also leaves a transmit interrupt pending exactly when enable bit 1 is set.
- R10: Writing the interrupt enable register (offset 1) with bit 1 set raises a pending transmit interrupt. The enable register (offset 1) and line control register (offset 3) read back the last byte written.
- R11: Writing 0x1A to the modem control register (offset 4) makes it read 0x9A. Every other write to it leaves it unchanged.
- R12: irq is registered and equals, one cycle after any change, the OR of the receive interrupt (rx_valid with enable bit 0) and the pending transmit interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| rx_valid | input | 1 | Console has a received byte |
| rx_data | input | 8 | Received byte |
| rx_pop | output | 1 | Consumes the received byte this cycle |
| tx_valid | output | 1 | One-cycle pulse carrying a transmitted byte |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a receive interrupt and a transmit interrupt pending together. Only there does the identification priority show, and only there can it be seen that a read reporting receive data still clears the transmit flag. The bench first enables both interrupts, which raises the transmit flag, and then holds rx_valid high. It reads the identification register twice, once with the byte present and once after withdrawing it, and expects 0x04 and then 0x01.

// File: rtl/uart_legacy_pkg.sv
package uart_legacy_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  // register offsets
  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_IER  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_IIR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_LCR  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_MCR  = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_LSR  = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_MSR  = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_SCR  = 3'd7;

  // identification codes
  localparam logic [REG_W-1:0] ID_NONE = 8'h01;
  localparam logic [REG_W-1:0] ID_TXE  = 8'h02;
  localparam logic [REG_W-1:0] ID_RXD  = 8'h04;

  // bit positions
  localparam int DLAB_BIT = 7;
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int LS_DR    = 0;
  localparam int LS_THRE  = 5;
  localparam int LS_TEMT  = 6;

  // modem control loopback probe
  localparam logic [REG_W-1:0] MC_PROBE = 8'h1A;
  localparam logic [REG_W-1:0] MC_ANSWER = 8'h9A;
endpackage

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_legacy_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr,
  input  logic             lc_wr,
  input  logic             mc_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] lcr,
  output logic [REG_W-1:0] ier,
  output logic [REG_W-1:0] ier_nxt,
  output logic [REG_W-1:0] mcr
);
  always_comb ier_nxt = en_wr ? wdata : ier;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr <= '0;
      ier <= '0;
      mcr <= '0;
    end else begin
      ier <= ier_nxt;
      if (lc_wr) lcr <= wdata;
      if (mc_wr && wdata == MC_PROBE) mcr <= MC_ANSWER;
    end
  end

  // R11: modem control only ever holds reset value or the probe answer
  p_mcr_values_r11: assert property (@(posedge clk) disable iff (rst)
    (mcr == '0) || (mcr == MC_ANSWER));
  // R11: a non-probe write leaves the register unchanged
  p_mcr_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (mc_wr && wdata != MC_PROBE) |=> $stable(mcr));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_legacy_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             dat_wr,
  input  logic             en_wr,
  input  logic             id_rd,
  input  logic [REG_W-1:0] ier_nxt,
  input  logic             rx_valid,
  output logic             tx_pend,
  output logic             irq
);
  logic tx_nxt;

  always_comb begin
    tx_nxt = tx_pend;
    if (id_rd)  tx_nxt = 1'b0;
    if (dat_wr) tx_nxt = ier_nxt[EN_TX];
    if (en_wr && ier_nxt[EN_TX]) tx_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pend <= 1'b0;
      irq     <= 1'b0;
    end else begin
      tx_pend <= tx_nxt;
      irq     <= (rx_valid & ier_nxt[EN_RX]) | tx_nxt;
    end
  end

  p_id_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (id_rd && !dat_wr && !en_wr) |=> !tx_pend);
  p_thri_raises_r10: assert property (@(posedge clk) disable iff (rst)
    (en_wr && ier_nxt[EN_TX]) |=> tx_pend);
  p_pend_drives_irq_r12: assert property (@(posedge clk) disable iff (rst)
    tx_pend |-> irq);
endmodule

// File: rtl/uart_read_path.sv
module uart_read_path
  import uart_legacy_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dlab,
  input  logic [REG_W-1:0]  lcr,
  input  logic [REG_W-1:0]  ier,
  input  logic [REG_W-1:0]  mcr,
  input  logic              tx_pend,
  input  logic              rx_valid,
  input  logic [REG_W-1:0]  rx_data,
  output logic              rx_pop,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] sel;
  logic [REG_W-1:0] lsr;

  always_comb begin
    lsr = '0;
    lsr[LS_DR]   = rx_valid;
    lsr[LS_THRE] = 1'b1;
    lsr[LS_TEMT] = 1'b1;
  end

  always_comb rx_pop = rd && addr == OFF_DATA && !dlab && rx_valid;

  always_comb begin
    sel = '0;
    case (addr)
      OFF_DATA: sel = (!dlab && rx_valid) ? rx_data : '0;
      OFF_IER:  sel = dlab ? '0 : ier;
      OFF_IIR:  sel = (rx_valid && ier[EN_RX]) ? ID_RXD :
                      tx_pend ? ID_TXE : ID_NONE;
      OFF_LCR:  sel = lcr;
      OFF_MCR:  sel = mcr;
      OFF_LSR:  sel = lsr;
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd ? sel : '0;
  end

  p_lsr_idle_tx_r7: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == OFF_LSR) |=> (rdata[LS_THRE] && rdata[LS_TEMT]));
  p_zero_regs_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && (addr == OFF_MSR || addr == OFF_SCR)) |=> rdata == '0);
  p_pop_needs_data_r3: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> rx_valid);
endmodule

// File: rtl/legacy_uart_regs.sv
module legacy_uart_regs
  import uart_legacy_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [REG_W-1:0]  rx_data,
  output logic              rx_pop,
  output logic              tx_valid,
  output logic [REG_W-1:0]  tx_data,
  output logic              irq
);
  logic [REG_W-1:0] lcr, ier, ier_nxt, mcr;
  logic dlab, dat_wr, en_wr, lc_wr, mc_wr, id_rd, tx_pend;

  always_comb begin
    dlab   = lcr[DLAB_BIT];
    dat_wr = bus_wr && bus_addr == OFF_DATA && !dlab;
    en_wr  = bus_wr && bus_addr == OFF_IER  && !dlab;
    lc_wr  = bus_wr && bus_addr == OFF_LCR;
    mc_wr  = bus_wr && bus_addr == OFF_MCR;
    id_rd  = bus_rd && bus_addr == OFF_IIR;
  end

  uart_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .en_wr(en_wr), .lc_wr(lc_wr), .mc_wr(mc_wr),
    .wdata(bus_wdata), .lcr(lcr), .ier(ier), .ier_nxt(ier_nxt), .mcr(mcr)
  );

  uart_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .dat_wr(dat_wr), .en_wr(en_wr), .id_rd(id_rd),
    .ier_nxt(ier_nxt), .rx_valid(rx_valid), .tx_pend(tx_pend), .irq(irq)
  );

  uart_read_path u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr), .dlab(dlab),
    .lcr(lcr), .ier(ier), .mcr(mcr), .tx_pend(tx_pend),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= dat_wr;
      if (dat_wr) tx_data <= bus_wdata;
    end
  end

  p_tx_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid || $past(dat_wr));
  p_dlab_no_tx_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_DATA && dlab) |=> !tx_valid);
  p_dlab_ier_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_IER && dlab) |=> $stable(ier));
endmodule

// File: tb/legacy_uart_regs_tb_top.sv
module legacy_uart_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_pop, tx_valid, irq;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  legacy_uart_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_pop(rx_pop), .tx_valid(tx_valid), .tx_data(tx_data),
    .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // read: strobe one cycle, returns data and the pop seen during the strobe
  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic pop);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 pop = rx_pop;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic p;
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    rd(3'd3, d, p); check("R1 lcr", d, 8'h00);
    rd(3'd1, d, p); check("R1 ier", d, 8'h00);
    rd(3'd4, d, p); check("R1 mcr", d, 8'h00);
    rd(3'd2, d, p); check("R1 iir", d, 8'h01);
    @(negedge clk); check("R2 idle rdata", bus_rdata, 8'h00);
  endtask

  task automatic t_rx_read;
    logic [7:0] d; logic p;
    rd(3'd0, d, p);
    check("R3 empty data", d, 8'h00); check("R3 empty pop", {7'd0, p}, 8'h00);
    rd(3'd5, d, p); check("R7 lsr empty", d, 8'h60);
    rx_valid = 1'b1; rx_data = 8'hA5;
    rd(3'd5, d, p); check("R7 lsr ready", d, 8'h61);
    rd(3'd0, d, p);
    check("R3 data", d, 8'hA5); check("R3 pop", {7'd0, p}, 8'h01);
    rx_valid = 1'b0;
  endtask

  task automatic t_regs;
    logic [7:0] d; logic p;
    wr(3'd3, 8'h1B); rd(3'd3, d, p); check("R10 lcr readback", d, 8'h1B);
    wr(3'd1, 8'h0C); rd(3'd1, d, p); check("R10 ier readback", d, 8'h0C);
    rd(3'd2, d, p); check("R10 no thri no pend", d, 8'h01);
    wr(3'd4, 8'h10); rd(3'd4, d, p); check("R11 other write", d, 8'h00);
    wr(3'd4, 8'h1A); rd(3'd4, d, p); check("R11 probe", d, 8'h9A);
    wr(3'd4, 8'h00); rd(3'd4, d, p); check("R11 hold", d, 8'h9A);
    wr(3'd7, 8'h55); rd(3'd7, d, p); check("R8 scratch", d, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd6, 8'hFF); wr(3'd5, 8'hFF);
    rd(3'd6, d, p); check("R8 msr", d, 8'h00);
    rd(3'd3, d, p); check("R8 lcr untouched", d, 8'h1B);
    rd(3'd1, d, p); check("R8 ier untouched", d, 8'h0C);
    check("R8 no tx", {7'd0, tx_valid}, 8'h00);
  endtask

  task automatic t_dlab;
    logic [7:0] d; logic p;
    wr(3'd3, 8'h83);
    rx_valid = 1'b1; rx_data = 8'h3C;
    rd(3'd0, d, p); check("R4 dll read", d, 8'h00); check("R4 no pop", {7'd0, p}, 8'h00);
    rd(3'd1, d, p); check("R4 dlm read", d, 8'h00);
    wr(3'd0, 8'h77); check("R4 no tx", {7'd0, tx_valid}, 8'h00);
    wr(3'd1, 8'h03);
    rx_valid = 1'b0;
    wr(3'd3, 8'h03);
    rd(3'd1, d, p); check("R4 ier unchanged", d, 8'h0C);
  endtask

  task automatic t_tx;
    logic [7:0] d; logic p;
    wr(3'd1, 8'h00);
    @(negedge clk);
    bus_addr = 3'd0; bus_wdata = 8'hC3; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R9 tx_valid", {7'd0, tx_valid}, 8'h01);
    check("R9 tx_data", tx_data, 8'hC3);
    @(negedge clk); check("R9 pulse one cycle", {7'd0, tx_valid}, 8'h00);
    rd(3'd2, d, p); check("R9 no pend without thri", d, 8'h01);
    wr(3'd1, 8'h02);
    check("R12 irq after ier", {7'd0, irq}, 8'h01);
    rd(3'd2, d, p); check("R10 thri raises", d, 8'h02);
    check("R12 irq drops", {7'd0, irq}, 8'h00);
    rd(3'd2, d, p); check("R6 cleared", d, 8'h01);
    wr(3'd0, 8'h11);
    check("R12 irq after data", {7'd0, irq}, 8'h01);
    rd(3'd2, d, p); check("R9 rearm", d, 8'h02);
  endtask

  task automatic t_priority;
    logic [7:0] d; logic p;
    wr(3'd1, 8'h03);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h42;
    rd(3'd2, d, p); check("R5 rx first", d, 8'h04);
    check("R12 irq rx held", {7'd0, irq}, 8'h01);
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk); check("R12 irq off", {7'd0, irq}, 8'h00);
    rd(3'd2, d, p); check("R6 cleared by rx report", d, 8'h01);
    wr(3'd1, 8'h01);
    @(negedge clk); rx_valid = 1'b1;
    @(negedge clk); check("R12 irq rx", {7'd0, irq}, 8'h01);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rx_read();
    t_regs();
    t_dlab();
    t_tx();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule